// File: doc/BRIEF.md
# DDR SDRAM Command Legality Checker

This block watches a decoded DDR SDRAM command stream on one clock and judges each command against the sequencing rules of a four-bank device. It keeps a model of which banks hold an open row. It also tracks the recovery windows that a write with auto precharge leaves behind, and the quiet period that follows a mode-register write. When a command breaks a rule, the checker raises a one-cycle error pulse with a code that names the rule. The offending command is then treated as though it never happened.

The checker is meant to sit beside a memory controller or a stimulus generator in a larger design, as a monitor. Its outputs give the per-bank open state and a flag that says the whole device is quiescent. The write recovery time is an integer clock count supplied on an input and sampled with each write that carries auto precharge. The burst length comes from the mode-register command itself.

Top module: `ddr_cmd_guard`

## Requirements
- R1: The strobes {cs_n,ras_n,cas_n,we_n} encode the commands as follows: 0011 activate, 0101 read, 0100 write, 0010 precharge, 0001 refresh, 0000 mode-register set, 0110 burst stop, 0111 NOP, and cs_n high is deselect. For activate, read, write and precharge, `ba` selects the bank. An accepted activate sets `bank_open[ba]`.
- R2: A precharge with `a10` low closes only bank `ba`. A precharge with `a10` high ignores `ba` and closes every bank.
- R3: A mode-register set is flagged with code 1 unless `all_idle` is high. An accepted one with `ba`=00 loads the burst length from `mode_bits`: 1 gives 2 beats, 2 gives 4 and 3 gives 8. Any other value leaves the burst length as it was. The burst length after reset is 8 beats.
- R4: For MRD_CYC-1 cycles after an accepted mode-register set, any command other than NOP or deselect is flagged with code 2. This check takes priority over every other rule.
- R5: A refresh (auto refresh, or self refresh entry with `cke` low) is flagged with code 3 unless `all_idle` is high.
- R6: A read or write to a bank that is not open is flagged with code 4. An activate to a bank that is already open is flagged with code 5.
- R7: A write with `a10` high closes its bank and starts a burst of BL/2 clocks, occupying the BL/2 cycles after the command. Any read or write in that window is flagged with code 6, whatever its bank. Once the window has passed, a read or write to another open bank is legal.
- R8: After a write with auto precharge issued in cycle t, an activate to that bank is flagged with code 7 before cycle t+BL/2+`t_dal`, and is legal from that cycle on. `all_idle` is low while a burst window or any recovery window is running.
- R9: A command is honoured only if `cke` was high in the previous cycle; otherwise it is treated as NOP. Burst stop is never flagged outside the window of R4.
- R10: The error of a command in cycle t appears in cycle t+1: `err_pulse` is high for that one cycle and `err_code` holds the rule's code, 0 meaning none. A flagged command changes no state. After reset all banks are closed, `all_idle` is high and no error is shown.
- R11: A read with `a10` high closes its bank at once and leaves no recovery window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cke | input | 1 | Clock-enable qualifier |
| cs_n | input | 1 | Chip select strobe, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write-enable strobe, active low |
| ba | input | 2 | Bank address |
| a10 | input | 1 | Auto-precharge / precharge-all bit |
| mode_bits | input | 3 | Burst-length field presented with a mode-register set |
| t_dal | input | 8 | Write recovery plus precharge time, in clocks |
| bank_open | output | 4 | Open-row flag per bank |
| all_idle | output | 1 | No bank open, no burst or recovery window running |
| err_pulse | output | 1 | One-cycle violation pulse |
| err_code | output | 3 | Code of the violated rule |

## Verification
The bench builds the block with its defaults: four banks, an 8-bit recovery count and a two-cycle gap after a mode-register write. This is enough to run overlapping recovery windows on different banks and to put a command in the single forbidden cycle after a mode write. It drives `t_dal` at 5, 0 and random small values. At 0 the recovery window equals the burst window, which exercises the earliest legal activate. All three burst lengths are loaded through the mode command, so burst windows of one, two and four clocks are covered.

// File: rtl/ddr_guard_pkg.sv
package ddr_guard_pkg;

  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4,
    CMD_REF = 3'd5,
    CMD_MRS = 3'd6,
    CMD_BST = 3'd7
  } cmd_e;

  typedef enum logic [2:0] {
    ERR_NONE       = 3'd0,
    ERR_MODE_BUSY  = 3'd1,
    ERR_MODE_GAP   = 3'd2,
    ERR_REF_BUSY   = 3'd3,
    ERR_ACC_CLOSED = 3'd4,
    ERR_ACT_OPEN   = 3'd5,
    ERR_BURST_LOCK = 3'd6,
    ERR_DAL_LOCK   = 3'd7
  } err_e;

  localparam int BCW = 3;  // burst length in clocks: 1, 2 or 4

  // Strobe decode; deselect and the no-operation pattern both give CMD_NOP.
  function automatic cmd_e decode_cmd(input logic cs_n, input logic ras_n,
                                      input logic cas_n, input logic we_n);
    cmd_e c;
    if (cs_n) c = CMD_NOP;
    else begin
      unique case ({ras_n, cas_n, we_n})
        3'b011:  c = CMD_ACT;
        3'b101:  c = CMD_RD;
        3'b100:  c = CMD_WR;
        3'b010:  c = CMD_PRE;
        3'b001:  c = CMD_REF;
        3'b000:  c = CMD_MRS;
        3'b110:  c = CMD_BST;
        default: c = CMD_NOP;
      endcase
    end
    return c;
  endfunction

  // Burst length field to clocks of data (two beats per clock).
  function automatic logic [BCW-1:0] burst_clocks(input logic [2:0] field,
                                                  input logic [BCW-1:0] keep);
    logic [BCW-1:0] r;
    unique case (field)
      3'd1:    r = BCW'(1);
      3'd2:    r = BCW'(2);
      3'd3:    r = BCW'(4);
      default: r = keep;
    endcase
    return r;
  endfunction

  // Countdown preload so that the bank frees exactly burst+dal cycles later.
  function automatic logic [15:0] recovery_load(input logic [BCW-1:0] bclk,
                                                input logic [15:0] dal);
    return 16'(bclk) + dal - 16'd1;
  endfunction

endpackage

// File: rtl/ddr_cmd_decode.sv
module ddr_cmd_decode
  import ddr_guard_pkg::*;
(
  input  logic cke_live,
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output cmd_e cmd
);
  always_comb begin
    if (cke_live) cmd = decode_cmd(cs_n, ras_n, cas_n, we_n);
    else          cmd = CMD_NOP;
  end
endmodule

// File: rtl/ddr_seq_timer.sv
module ddr_seq_timer
  import ddr_guard_pkg::*;
#(
  parameter int MRD_CYC = 2,
  localparam int GAP_W = (MRD_CYC < 2) ? 1 : $clog2(MRD_CYC + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           mrs_start,
  input  logic           wap_start,
  input  logic [BCW-1:0] burst_clks,
  output logic           gap_active,
  output logic           burst_busy
);
  localparam logic [GAP_W-1:0] GAP_LOAD = (MRD_CYC < 2) ? '0 : GAP_W'(MRD_CYC - 1);

  logic [GAP_W-1:0] gap_cnt;
  logic [BCW-1:0]   burst_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap_cnt <= '0;
    end else if (mrs_start) begin
      gap_cnt <= GAP_LOAD;
    end else if (gap_cnt != '0) begin
      gap_cnt <= gap_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      burst_cnt <= '0;
    end else if (wap_start) begin
      burst_cnt <= burst_clks;
    end else if (burst_cnt != '0) begin
      burst_cnt <= burst_cnt - 1'b1;
    end
  end

  assign gap_active = (gap_cnt != '0);
  assign burst_busy = (burst_cnt != '0);
endmodule

// File: rtl/ddr_bank_track.sv
module ddr_bank_track
  import ddr_guard_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int DAL_W     = 8,
  localparam int BA_W = $clog2(NUM_BANKS),
  localparam int RW   = DAL_W + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ev_act,
  input  logic                 ev_close_one,
  input  logic                 ev_close_all,
  input  logic                 ev_wap,
  input  logic [BA_W-1:0]      bank_sel,
  input  logic [BCW-1:0]       burst_clks,
  input  logic [DAL_W-1:0]     t_dal,
  output logic [NUM_BANKS-1:0] bank_open,
  output logic [NUM_BANKS-1:0] rec_busy
);
  logic [15:0] load_full;
  logic [RW-1:0] load_val;

  assign load_full = recovery_load(burst_clks, 16'(t_dal));
  assign load_val  = load_full[RW-1:0];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic          hit;
    logic          open_q;
    logic [RW-1:0] rec_q;

    assign hit = (bank_sel == BA_W'(b));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        open_q <= 1'b0;
        rec_q  <= '0;
      end else begin
        if (ev_wap && hit)       rec_q <= load_val;
        else if (rec_q != '0)    rec_q <= rec_q - 1'b1;
        if (ev_close_all || (ev_close_one && hit)) open_q <= 1'b0;
        else if (ev_act && hit)                    open_q <= 1'b1;
      end
    end

    assign bank_open[b] = open_q;
    assign rec_busy[b]  = (rec_q != '0);
  end
endmodule

// File: rtl/ddr_cmd_guard.sv
module ddr_cmd_guard
  import ddr_guard_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int DAL_W     = 8,
  parameter int MRD_CYC   = 2,
  localparam int BA_W = $clog2(NUM_BANKS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cke,
  input  logic                 cs_n,
  input  logic                 ras_n,
  input  logic                 cas_n,
  input  logic                 we_n,
  input  logic [BA_W-1:0]      ba,
  input  logic                 a10,
  input  logic [2:0]           mode_bits,
  input  logic [DAL_W-1:0]     t_dal,
  output logic [NUM_BANKS-1:0] bank_open,
  output logic                 all_idle,
  output logic                 err_pulse,
  output logic [2:0]           err_code
);
  logic           cke_q;
  logic [BCW-1:0] bl_clks;
  cmd_e           cmd;
  err_e           rule;
  logic           rule_err;
  logic           gap_active, burst_busy;
  logic [NUM_BANKS-1:0] rec_busy;

  // Named events for the checker
  logic ev_act, ev_rd_ok, ev_wr_ok, ev_close_one, ev_close_all;
  logic ev_wap, ev_mrs_ok, ev_ref_ok, ev_accept_cmd;
  logic sel_open, sel_rec;

  always_ff @(posedge clk) begin
    if (!rst_n) cke_q <= 1'b0;
    else        cke_q <= cke;
  end

  ddr_cmd_decode u_dec (
    .cke_live(cke_q), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .cmd(cmd)
  );

  assign sel_open = bank_open[ba];
  assign sel_rec  = rec_busy[ba];
  assign all_idle = (bank_open == '0) && (rec_busy == '0) && !burst_busy;

  always_comb begin
    rule = ERR_NONE;
    if (gap_active && cmd != CMD_NOP) begin
      rule = ERR_MODE_GAP;
    end else begin
      unique case (cmd)
        CMD_ACT: begin
          if (sel_rec)       rule = ERR_DAL_LOCK;
          else if (sel_open) rule = ERR_ACT_OPEN;
        end
        CMD_RD, CMD_WR: begin
          if (burst_busy)     rule = ERR_BURST_LOCK;
          else if (!sel_open) rule = ERR_ACC_CLOSED;
        end
        CMD_REF: if (!all_idle) rule = ERR_REF_BUSY;
        CMD_MRS: if (!all_idle) rule = ERR_MODE_BUSY;
        default: rule = ERR_NONE;
      endcase
    end
  end

  assign rule_err      = (rule != ERR_NONE);
  assign ev_act        = !rule_err && cmd == CMD_ACT;
  assign ev_rd_ok      = !rule_err && cmd == CMD_RD;
  assign ev_wr_ok      = !rule_err && cmd == CMD_WR;
  assign ev_close_all  = !rule_err && cmd == CMD_PRE && a10;
  assign ev_close_one  = (!rule_err && cmd == CMD_PRE && !a10) || ((ev_rd_ok || ev_wr_ok) && a10);
  assign ev_wap        = ev_wr_ok && a10;
  assign ev_mrs_ok     = !rule_err && cmd == CMD_MRS;
  assign ev_ref_ok     = !rule_err && cmd == CMD_REF;
  assign ev_accept_cmd = !rule_err && cmd != CMD_NOP;

  ddr_seq_timer #(.MRD_CYC(MRD_CYC)) u_tmr (
    .clk(clk), .rst_n(rst_n), .mrs_start(ev_mrs_ok), .wap_start(ev_wap),
    .burst_clks(bl_clks), .gap_active(gap_active), .burst_busy(burst_busy)
  );

  ddr_bank_track #(.NUM_BANKS(NUM_BANKS), .DAL_W(DAL_W)) u_banks (
    .clk(clk), .rst_n(rst_n), .ev_act(ev_act), .ev_close_one(ev_close_one),
    .ev_close_all(ev_close_all), .ev_wap(ev_wap), .bank_sel(ba),
    .burst_clks(bl_clks), .t_dal(t_dal), .bank_open(bank_open), .rec_busy(rec_busy)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bl_clks <= BCW'(4);
    end else if (ev_mrs_ok && ba == '0) begin
      bl_clks <= burst_clocks(mode_bits, bl_clks);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_pulse <= 1'b0;
      err_code  <= 3'd0;
    end else begin
      err_pulse <= rule_err;
      err_code  <= rule;
    end
  end
endmodule

// File: rtl/ddr_cmd_guard_chk.sv
module ddr_cmd_guard_chk #(
  parameter int NUM_BANKS = 4,
  parameter int MRD_CYC   = 2,
  localparam int BA_W = $clog2(NUM_BANKS)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [BA_W-1:0]      ba,
  input logic [NUM_BANKS-1:0] bank_open,
  input logic [NUM_BANKS-1:0] rec_busy,
  input logic                 all_idle,
  input logic                 err_pulse,
  input logic                 rule_err,
  input logic                 burst_busy,
  input logic                 ev_act,
  input logic                 ev_rd_ok,
  input logic                 ev_wr_ok,
  input logic                 ev_close_all,
  input logic                 ev_mrs_ok,
  input logic                 ev_ref_ok,
  input logic                 ev_accept_cmd
);
  assert_act_opens_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ev_act |=> bank_open[$past(ba)]);

  assert_close_all_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_close_all |=> (bank_open == '0));

  assert_mode_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_mrs_ok |-> all_idle);

  assert_mode_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_mrs_ok && MRD_CYC >= 2) |=> !ev_accept_cmd);

  assert_ref_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ref_ok |-> all_idle);

  assert_act_closed_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_act |-> !bank_open[ba]);

  assert_burst_lock_R7: assert property (@(posedge clk) disable iff (!rst_n)
    burst_busy |-> !(ev_rd_ok || ev_wr_ok));

  assert_recovery_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_busy != '0) |-> !all_idle);

  assert_reject_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rule_err |=> (err_pulse && $stable(bank_open)));
endmodule

bind ddr_cmd_guard ddr_cmd_guard_chk #(.NUM_BANKS(NUM_BANKS), .MRD_CYC(MRD_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .ba(ba), .bank_open(bank_open), .rec_busy(rec_busy),
  .all_idle(all_idle), .err_pulse(err_pulse), .rule_err(rule_err),
  .burst_busy(burst_busy), .ev_act(ev_act), .ev_rd_ok(ev_rd_ok), .ev_wr_ok(ev_wr_ok),
  .ev_close_all(ev_close_all), .ev_mrs_ok(ev_mrs_ok), .ev_ref_ok(ev_ref_ok),
  .ev_accept_cmd(ev_accept_cmd)
);

// File: tb/ddr_cmd_guard_bench.sv
`timescale 1ns/1ps
module ddr_cmd_guard_bench;
  localparam logic [3:0] S_ACT = 4'b0011, S_RD = 4'b0101, S_WR = 4'b0100,
                         S_PRE = 4'b0010, S_REF = 4'b0001, S_MRS = 4'b0000,
                         S_BST = 4'b0110, S_NOP = 4'b0111, S_DES = 4'b1111;
  localparam int MRD = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cke = 1'b0, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0] ba = '0;
  logic a10 = 1'b0;
  logic [2:0] mode_bits = '0;
  logic [7:0] t_dal = 8'd5;
  logic [3:0] bank_open;
  logic all_idle, err_pulse;
  logic [2:0] err_code;

  int n_cmp = 0, n_bad = 0;

  always #2 clk = ~clk;

  ddr_cmd_guard u_ddr_cmd_guard (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .ba(ba), .a10(a10), .mode_bits(mode_bits), .t_dal(t_dal),
    .bank_open(bank_open), .all_idle(all_idle), .err_pulse(err_pulse), .err_code(err_code)
  );

  // Reference model: timestamps in cycles since reset
  int  cyc = 0;
  bit  m_open[4];
  int  m_rec_free[4];
  int  m_burst_last = -1;
  int  m_gap_end = 0;
  int  m_bl = 8;
  bit  m_cke_prev = 0;

  function automatic bit idle_at(int n);
    bit r = 1;
    for (int i = 0; i < 4; i++) if (m_open[i] || n < m_rec_free[i]) r = 0;
    if (n <= m_burst_last) r = 0;
    return r;
  endfunction

  function automatic logic [3:0] open_vec();
    logic [3:0] v;
    for (int i = 0; i < 4; i++) v[i] = m_open[i];
    return v;
  endfunction

  task automatic check(input string tag, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s cycle %0d: actual=%0d expected=%0d", tag, what, cyc, act, exp);
    end
  endtask

  task automatic step(input logic [3:0] s, input int b, input bit ap, input int mb,
                      input bit ck, input string tag);
    int code = 0;
    bit live;
    int bc;
    cke = ck; {cs_n, ras_n, cas_n, we_n} = s; ba = 2'(b); a10 = ap; mode_bits = 3'(mb);
    live = m_cke_prev;
    m_cke_prev = ck;
    bc = m_bl / 2;
    if (live && !s[3] && s != S_NOP) begin
      if (cyc < m_gap_end) code = 2;
      else case (s)
        S_ACT: if (cyc < m_rec_free[b]) code = 7;
               else if (m_open[b]) code = 5;
               else m_open[b] = 1;
        S_RD, S_WR: if (cyc <= m_burst_last) code = 6;
               else if (!m_open[b]) code = 4;
               else if (ap) begin
                 m_open[b] = 0;
                 if (s == S_WR) begin
                   m_burst_last = cyc + bc;
                   m_rec_free[b] = cyc + bc + int'(t_dal);
                 end
               end
        S_PRE: if (ap) for (int i = 0; i < 4; i++) m_open[i] = 0;
               else m_open[b] = 0;
        S_REF: if (!idle_at(cyc)) code = 3;
        S_MRS: if (!idle_at(cyc)) code = 1;
               else begin
                 m_gap_end = cyc + MRD;
                 if (b == 0) begin
                   if (mb == 1) m_bl = 2;
                   else if (mb == 2) m_bl = 4;
                   else if (mb == 3) m_bl = 8;
                 end
               end
        default: ;
      endcase
    end
    @(posedge clk);
    #1;
    check(tag, "err_code", int'(err_code), code);
    check(tag, "err_pulse", int'(err_pulse), int'(code != 0));
    check(tag, "bank_open", int'(bank_open), int'(open_vec()));
    check(tag, "all_idle", int'(all_idle), int'(idle_at(cyc + 1)));
    cyc++;
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL R10 watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10: reset state
    check("R10", "reset err_pulse", int'(err_pulse), 0);
    check("R10", "reset bank_open", int'(bank_open), 0);
    check("R10", "reset all_idle", int'(all_idle), 1);
    rst_n = 1'b1;

    // R9: clock enable low in the previous cycle, activate ignored
    step(S_ACT, 0, 0, 0, 1, "R9");
    step(S_NOP, 0, 0, 0, 1, "R9");
    // R3 / R4: mode write, then one forbidden cycle
    step(S_MRS, 0, 0, 2, 1, "R3");
    step(S_ACT, 0, 0, 0, 1, "R4");
    step(S_ACT, 0, 0, 0, 1, "R1");
    // R6
    step(S_ACT, 0, 0, 0, 1, "R6");
    step(S_ACT, 2, 0, 0, 1, "R1");
    step(S_RD, 1, 0, 0, 1, "R6");
    step(S_RD, 0, 0, 0, 1, "R1");
    step(S_WR, 2, 0, 0, 1, "R1");
    // R3 / R5 with banks open
    step(S_MRS, 0, 0, 1, 1, "R3");
    step(S_REF, 0, 0, 0, 1, "R5");
    step(S_BST, 3, 0, 0, 1, "R9");
    // R2
    step(S_PRE, 2, 0, 0, 1, "R2");
    step(S_PRE, 3, 1, 0, 1, "R2");
    step(S_REF, 0, 0, 0, 1, "R5");
    // R3: 8-beat bursts, R4: burst stop in gap
    step(S_MRS, 0, 0, 3, 1, "R3");
    step(S_BST, 0, 0, 0, 1, "R4");
    step(S_ACT, 0, 0, 0, 1, "R1");
    step(S_ACT, 1, 0, 0, 1, "R1");
    // R7 / R8: write with auto precharge, 4-clock burst, t_dal 5
    t_dal = 8'd5;
    step(S_WR, 0, 1, 0, 1, "R7");
    step(S_RD, 1, 0, 0, 1, "R7");
    step(S_MRS, 0, 0, 1, 1, "R8");
    step(S_NOP, 0, 0, 0, 1, "R8");
    step(S_WR, 1, 0, 0, 1, "R7");
    step(S_RD, 1, 0, 0, 1, "R7");
    for (int k = 0; k < 4; k++) step(S_ACT, 0, 0, 0, 1, "R8");
    // R11: read with auto precharge
    step(S_RD, 1, 1, 0, 1, "R11");
    step(S_RD, 1, 0, 0, 1, "R11");
    step(S_ACT, 1, 0, 0, 1, "R11");
    // R9: clock enable dropped for one cycle
    step(S_NOP, 0, 0, 0, 0, "R9");
    step(S_PRE, 0, 1, 0, 1, "R9");
    step(S_PRE, 0, 1, 0, 1, "R2");
    // R3 reserved field keeps length, then 2-beat with t_dal 0
    step(S_MRS, 0, 0, 0, 1, "R3");
    step(S_MRS, 1, 0, 3, 1, "R3");
    step(S_NOP, 0, 0, 0, 1, "R3");
    step(S_MRS, 0, 0, 1, 1, "R3");
    step(S_DES, 0, 0, 0, 1, "R4");
    step(S_ACT, 3, 0, 0, 1, "R1");
    t_dal = 8'd0;
    step(S_WR, 3, 1, 0, 1, "R8");
    step(S_ACT, 3, 0, 0, 1, "R8");
    step(S_PRE, 0, 1, 0, 1, "R2");

    // Mixed traffic against the model
    for (int k = 0; k < 3000; k++) begin
      logic [3:0] pick[8] = '{S_ACT, S_RD, S_WR, S_PRE, S_REF, S_MRS, S_BST, S_NOP};
      int r = int'($urandom_range(0, 15));
      logic [3:0] s = (r < 8) ? pick[r] : ((r < 12) ? S_ACT : ((r < 14) ? S_PRE : S_WR));
      if ($urandom_range(0, 7) == 0) t_dal = 8'($urandom_range(0, 6));
      step(s, int'($urandom_range(0, 3)), bit'($urandom_range(0, 1)),
           int'($urandom_range(0, 4)), ($urandom_range(0, 15) != 0), "R10");
    end
    finish_run();
  end
endmodule